// File: doc/BRIEF.md
# Signed Integer Divide Unit

This unit is a multi-cycle signed integer divider for a processor execution pipeline. A single-cycle `start` pulse hands it a dividend, a divisor and a width-select bit. A low `wide` selects a 32-bit divide and a high `wide` selects a 64-bit divide. Both operands are two's-complement values of the selected width. Later, a one-cycle `done` pulse comes back with the quotient truncated toward zero. The unit has no remainder output, no flag outputs and no trap. A zero divisor gives a zero result. The most negative value divided by minus one wraps back to the most negative value.

Internally the divider converts both operands to unsigned magnitudes. It then runs a radix-2 restoring iteration that produces one quotient bit per clock. At the end it negates the quotient when the operand signs differ. One shared datapath serves both widths. In 32-bit mode the dividend magnitude is loaded left-aligned, so the iteration stops after 32 steps. A zero divisor skips the iteration entirely.

Top module: `sdiv_unit`

## Requirements
- R1: With `wide`=0 only bits [31:0] of each operand are used and bits [63:32] of `quotient` are zero. With `wide`=1 all 64 bits are used.
- R2: When the dividend and the nonzero divisor have the same sign, `quotient` is the non-negative quotient of the magnitudes.
- R3: A divisor that is zero in the selected width gives `quotient`=0. `done` is then high in the cycle right after the edge that accepted `start`.
- R4: When the signs of dividend and divisor differ, `quotient` is the negated magnitude quotient, so division truncates toward zero.
- R5: `done` is high for exactly one cycle, and `quotient` holds the result during that cycle.
- R6: The most negative value divided by -1 returns the most negative value of the selected width (0x0000_0000_8000_0000 or 0x8000_0000_0000_0000).
- R7: With a nonzero divisor, `done` goes high exactly 32 edges (`wide`=0) or 64 edges (`wide`=1) after the edge that accepted `start`.
- R8: `busy` is high from the accepting edge through the `done` cycle. A `start` pulse while `busy` is high is ignored: the running result and its timing are unchanged. Operands may change after the accepting edge.
- R9: After reset (`rstN` low), `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; accepted only while idle |
| wide | input | 1 | 0 = 32-bit divide, 1 = 64-bit divide |
| dividend | input | 64 | Signed dividend |
| divisor | input | 64 | Signed divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 64 | Signed truncated quotient, valid while `done` is high |

## Verification
The hardest condition to create is a second request that arrives while a divide is still running. The bench pulses `start` with different operands a few cycles into an operation. It then checks that the first result still appears at the expected cycle. It also changes the operand inputs right after acceptance and fills the unused upper halves in 32-bit mode with noise. This shows that only the latched low bits reach the result. The wrap-around case and the zero divisor are driven as directed cases at both widths, and these runs also check the early completion.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } divState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands and magnitudes
    logic step;   // one restoring iteration
  } divCtrl_t;

endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     zeroIn,     // selected-width divisor is zero (from datapath)
  input  logic     wideHeld,   // latched width select (from datapath)
  output divCtrl_t strobes,
  output logic     busy,
  output logic     done
);

  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(HALF_W - 1);

  divState_t       state, stateNext;
  logic [CNT_W-1:0] stepCnt;
  logic             lastStep;

  assign lastStep = (stepCnt == (wideHeld ? LAST_WIDE : LAST_NARROW));

  always_comb begin
    stateNext    = state;
    strobes.load = 1'b0;
    strobes.step = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          stateNext    = zeroIn ? ST_FINISH : ST_RUN;
        end
      end
      ST_RUN: begin
        strobes.step = 1'b1;
        if (lastStep) stateNext = ST_FINISH;
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobes.load)      stepCnt <= '0;
      else if (strobes.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

  // R5: the result strobe lasts a single cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: iteration count never passes the selected width
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (stepCnt <= (wideHeld ? LAST_WIDE : LAST_NARROW)));

  // R8: a start seen mid-run does not restart or end the run
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !lastStep && start) |=> (state == ST_RUN && stepCnt != '0));

endmodule

// File: rtl/sdiv_datapath.sv
module sdiv_datapath
  import sdiv_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  divCtrl_t          strobes,
  input  logic              wideIn,
  input  logic [DATA_W-1:0] dividendIn,
  input  logic [DATA_W-1:0] divisorIn,
  output logic              zeroIn,
  output logic              wideHeld,
  output logic              zeroHeld,
  output logic [DATA_W-1:0] result
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] remReg, quoReg, dvsReg;
  logic              negReg;

  // magnitude of an operand in the selected width, zero-extended
  function automatic logic [DATA_W-1:0] magOf(input logic [DATA_W-1:0] v, input logic w);
    logic [HALF_W-1:0] lo;
    lo = v[HALF_W-1:0];
    if (w) magOf = v[DATA_W-1] ? (~v + 1'b1) : v;
    else   magOf = {{HALF_W{1'b0}}, (lo[HALF_W-1] ? (~lo + 1'b1) : lo)};
  endfunction

  logic signA, signB;
  logic [DATA_W-1:0] magA, magB;

  assign signA  = wideIn ? dividendIn[DATA_W-1] : dividendIn[HALF_W-1];
  assign signB  = wideIn ? divisorIn[DATA_W-1]  : divisorIn[HALF_W-1];
  assign magA   = magOf(dividendIn, wideIn);
  assign magB   = magOf(divisorIn, wideIn);
  assign zeroIn = wideIn ? (divisorIn == '0) : (divisorIn[HALF_W-1:0] == '0);

  // restoring step
  logic [DATA_W:0]   trial;
  logic              fits;
  logic [DATA_W-1:0] remNext;

  assign trial   = {remReg, quoReg[DATA_W-1]};
  assign fits    = (trial >= {1'b0, dvsReg});
  assign remNext = fits ? DATA_W'(trial - {1'b0, dvsReg}) : trial[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg   <= '0;
      quoReg   <= '0;
      dvsReg   <= '0;
      negReg   <= 1'b0;
      wideHeld <= 1'b0;
      zeroHeld <= 1'b0;
    end else if (strobes.load) begin
      remReg   <= '0;
      quoReg   <= wideIn ? magA : {magA[HALF_W-1:0], {HALF_W{1'b0}}};
      dvsReg   <= magB;
      negReg   <= signA ^ signB;
      wideHeld <= wideIn;
      zeroHeld <= zeroIn;
    end else if (strobes.step) begin
      remReg <= remNext;
      quoReg <= {quoReg[DATA_W-2:0], fits};
    end
  end

  // sign correction, truncated to the selected width
  logic [DATA_W-1:0] quoNeg;
  logic [HALF_W-1:0] quoLow;

  assign quoNeg = ~quoReg + 1'b1;
  assign quoLow = negReg ? quoNeg[HALF_W-1:0] : quoReg[HALF_W-1:0];

  always_comb begin
    if (zeroHeld)      result = '0;
    else if (wideHeld) result = negReg ? quoNeg : quoReg;
    else               result = {{HALF_W{1'b0}}, quoLow};
  end

  // R2: partial remainder stays below the divisor after every step
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (remReg < dvsReg));

  // R3: a zero divisor never enters the iteration
  a_r3_no_step_on_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && zeroIn) |=> !strobes.step);

endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
  import sdiv_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wide,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] quotient
);

  localparam int HALF_W = DATA_W / 2;

  divCtrl_t strobes;
  logic     zeroIn, wideHeld, zeroHeld;

  sdiv_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .zeroIn  (zeroIn),
    .wideHeld(wideHeld),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  sdiv_datapath #(.DATA_W(DATA_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wideIn    (wide),
    .dividendIn(dividend),
    .divisorIn (divisor),
    .zeroIn    (zeroIn),
    .wideHeld  (wideHeld),
    .zeroHeld  (zeroHeld),
    .result    (quotient)
  );

  // R3: zero divisor yields zero at the strobe
  a_r3_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    (done && zeroHeld) |-> (quotient == '0));

  // R1: narrow results are zero-extended
  a_r1_narrow_upper: assert property (@(posedge clk) disable iff (!rstN)
    (done && !wideHeld) |-> (quotient[DATA_W-1:HALF_W] == '0));

  // R8: busy covers the strobe cycle
  a_r8_busy_with_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

// File: tb/sdiv_unit_test.sv
`timescale 1ns/1ps
module sdiv_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        wide = 1'b0;
  logic [63:0] dividend = '0;
  logic [63:0] divisor = '0;
  logic        busy, done;
  logic [63:0] quotient;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdiv_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .wide(wide),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] refDiv(input logic [63:0] a, input logic [63:0] b, input logic w);
    longint sa, sb;
    int     na, nb;
    if (w) begin
      sa = a; sb = b;
      if (sb == 0) return 64'd0;
      if (sa == 64'sh8000_0000_0000_0000 && sb == -1) return 64'h8000_0000_0000_0000;
      return 64'(sa / sb);
    end else begin
      na = a[31:0]; nb = b[31:0];
      if (nb == 0) return 64'd0;
      if (na == 32'sh8000_0000 && nb == -1) return 64'h0000_0000_8000_0000;
      return {32'd0, 32'(na / nb)};
    end
  endfunction

  function automatic bit isZeroDiv(input logic [63:0] b, input logic w);
    return w ? (b == 64'd0) : (b[31:0] == 32'd0);
  endfunction

  // one divide, checking value, latency and pulse width
  task automatic runDiv(input logic [63:0] a, input logic [63:0] b, input logic w,
                        input string tag, input bit midStart);
    logic [63:0] exp;
    int lat, expLat;
    exp    = refDiv(a, b, w);
    expLat = isZeroDiv(b, w) ? 0 : (w ? 64 : 32);
    @(negedge clk);
    start = 1'b1; wide = w; dividend = a; divisor = b;
    @(posedge clk); #1;
    start = 1'b0; wide = ~w; dividend = {$urandom, $urandom}; divisor = {$urandom, $urandom};
    lat = 0;
    while (!done && lat < 100) begin
      if (midStart && lat == 3) begin
        check(busy == 1'b1, {tag, " R8 busy"}, 64'(busy), 64'd1);
        start = 1'b1; divisor = 64'd1; dividend = 64'd7;
        @(posedge clk); #1;
        start = 1'b0;
      end else begin
        @(posedge clk); #1;
      end
      lat++;
    end
    check(quotient == exp, tag, quotient, exp);
    check(lat == expLat, {tag, " R7 latency"}, 64'(lat), 64'(expLat));
    @(posedge clk); #1;
    check(done == 1'b0, {tag, " R5 pulse"}, 64'(done), 64'd0);
  endtask

  task automatic testReset;
    check(busy == 1'b0, "R9 busy", 64'(busy), 64'd0);
    check(done == 1'b0, "R9 done", 64'(done), 64'd0);
  endtask

  task automatic testSameSign;
    runDiv(64'd100, 64'd7, 1'b0, "R2 pos/pos narrow", 0);
    runDiv(64'hFFFF_FFFF_FFFF_FF9C, 64'hFFFF_FFFF_FFFF_FFF9, 1'b1, "R2 neg/neg wide", 0);
    runDiv(64'h7FFF_FFFF_FFFF_FFFF, 64'd3, 1'b1, "R2 max wide", 0);
  endtask

  task automatic testMixedSign;
    runDiv(64'h0000_0000_FFFF_FF9C, 64'd7, 1'b0, "R4 neg/pos narrow", 0);
    runDiv(64'd100, 64'hFFFF_FFFF_FFFF_FFF9, 1'b1, "R4 pos/neg wide", 0);
    runDiv(64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R4 by minus one", 0);
  endtask

  task automatic testZero;
    runDiv(64'd1234, 64'd0, 1'b0, "R3 zero narrow", 0);
    runDiv(64'h8000_0000_0000_0000, 64'd0, 1'b1, "R3 zero wide", 0);
    runDiv(64'd99, 64'hABCD_0000_0000_0000, 1'b0, "R3 R1 low half zero", 0);
  endtask

  task automatic testMinNeg;
    runDiv(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0, "R6 narrow", 0);
    runDiv(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R6 wide", 0);
    runDiv(64'h8000_0000_0000_0000, 64'd2, 1'b1, "R6 min by two", 0);
  endtask

  task automatic testNarrowJunk;
    runDiv(64'hDEAD_BEEF_0000_0064, 64'h1234_5678_FFFF_FFF6, 1'b0, "R1 junk upper", 0);
  endtask

  task automatic testBusyIgnore;
    runDiv(64'd1000, 64'd9, 1'b0, "R8 ignore narrow", 1);
    runDiv(64'hFFFF_FFFF_0000_0000, 64'd12345, 1'b1, "R8 ignore wide", 1);
  endtask

  task automatic testRandom;
    for (int i = 0; i < 24; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = (i % 3 == 0) ? 64'($urandom % 50) - 64'd25 : {$urandom, $urandom} >> ($urandom % 60);
      runDiv(a, b, i[0], "R2 R4 random", 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 testReset();
    @(negedge clk) rstN = 1'b1;
    testSameSign();
    testMixedSign();
    testZero();
    testMinNeg();
    testNarrowJunk();
    testBusyIgnore();
    testRandom();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule